// File: doc/BRIEF.md
# Page-addressed monochrome LCD controller

This block keeps the picture of a 128 x 64 one-bit display in 1 KiB of on-chip video memory. The memory is split into eight horizontal bands of eight pixel rows. Each band holds 128 column bytes. Software fills the memory through a small set of 32-bit registers. A mode register decides whether writes to the data register are stored as pixels, read as commands, or dropped. Page-select commands move a write cursor to the start of a band. Each stored byte then advances the cursor by one column.

A separate scan port lets a display refresher fetch any pixel by its (x, y) coordinate. The pixel bit appears one clock later. Scan reads run on their own memory port, so they never hold up or disturb register writes.

Register reads are combinational. Only the interrupt-control word is readable. Every other address, including the mode register, reads as zero.

Top module: `lcdpg_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the mode in the invalid state and moves the cursor to page 0, column 0. The interrupt-control word reads 0 after reset. Video memory is not cleared by reset.
- R2: A write to offset 0x180 stores the full 32-bit interrupt-control word, and a read at 0x180 returns it. A read at any other offset, including 0x1AC, 0x1BC and 0x1C0, returns 0.
- R3: Writing exactly 0x00100011 to offset 0x1AC selects data mode, and writing exactly 0x00104011 selects command mode. Any other value selects the invalid mode, in which data-register writes change neither memory nor cursor.
- R4: Writing a full 32-bit value from 0xB0 to 0xB7 to the instruction register (offset 0x1BC) selects page (value - 0xB0) and sets the column to 0, in every mode. Any other value, such as 0xB8 or 0x1B1, is ignored.
- R5: In command mode, a data-register write (offset 0xC0 above 0x100, that is 0x1C0) of 0xB0 to 0xB7 selects a page exactly as R4 does. Other values are ignored, and nothing is stored.
- R6: In data mode, a data-register write stores bits [7:0] of the written word at byte address page*128 + column, and then increments the column.
- R7: The column wraps from 127 to 0 without changing the page.
- R8: The scan port returns bit (y mod 8) of the byte at address x + (y/8)*128, registered one clock after x and y are presented. Bit 0 is the top row of a page.
- R9: A scan read in the same cycle as a data-mode store returns correct data, and the store still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| scan_x | input | 7 | Scan column 0..127 |
| scan_y | input | 6 | Scan row 0..63 |
| scan_pix | output | 1 | Pixel at the scan coordinate, one cycle later |

## Verification
The hardest case to reach from the ports is a column wrap. It takes 128 stores in one page before the 129th store lands back on column 0. The bench reaches it with a loop that writes marker bytes in the first and last columns, and then checks through the scan port that the extra byte replaced column 0. A second hard case is the invalid mode: a dropped write leaves nothing visible by itself. The bench therefore follows the dropped write with a store in data mode and checks which column that store reached.

// File: rtl/lcdpg_pkg.sv
// Package: shared constants and types for the page-addressed LCD controller.
// Assumes a 32-bit register bus with byte offsets.
package lcdpg_pkg;
    localparam logic [11:0] OFS_IRQCTL = 12'h180;
    localparam logic [11:0] OFS_MODE   = 12'h1AC;
    localparam logic [11:0] OFS_INSTR  = 12'h1BC;
    localparam logic [11:0] OFS_DATA   = 12'h1C0;

    localparam logic [31:0] MAGIC_DATA = 32'h0010_0011;
    localparam logic [31:0] MAGIC_CMD  = 32'h0010_4011;

    localparam logic [31:0] PAGE_CMD_BASE = 32'h0000_00B0;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_DATA = 2'd1,
        MODE_CMD  = 2'd2
    } lcd_mode_e;

    // True when a full 32-bit word is a page-select command for npages pages.
    function automatic logic is_page_cmd(input logic [31:0] v, input int npages);
        return (v >= PAGE_CMD_BASE) && (v < PAGE_CMD_BASE + 32'(npages));
    endfunction
endpackage

// File: rtl/lcdpg_regif.sv
// Register decoder: holds the interrupt-control word and the interface mode,
// turns bus writes into cursor-load and pixel-store requests, and drives read data.
// Assumes one write per cycle and combinational reads.
module lcdpg_regif
    import lcdpg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PAGES  = 8,
    localparam int PAGE_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              pg_load,
    output logic [PAGE_W-1:0] pg_idx,
    output logic              store_en,
    output logic [7:0]        store_byte
);
    lcd_mode_e   mode_q;
    logic [31:0] irqctl_q;
    logic        hit_irq, hit_mode, hit_ins, hit_dat, cmd_ok;

    // Address decode of the write strobe.
    always_comb begin
        hit_irq  = wr && (addr == ADDR_W'(OFS_IRQCTL));
        hit_mode = wr && (addr == ADDR_W'(OFS_MODE));
        hit_ins  = wr && (addr == ADDR_W'(OFS_INSTR));
        hit_dat  = wr && (addr == ADDR_W'(OFS_DATA));
        cmd_ok   = is_page_cmd(wdata, PAGES);
    end

    // Interrupt-control storage (read-back only, no side effect).
    always_ff @(posedge clk) begin
        if (!rst_n)       irqctl_q <= '0;
        else if (hit_irq) irqctl_q <= wdata;
    end

    // Mode register: only the two exact magic words are accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else if (hit_mode) begin
            if (wdata == MAGIC_DATA)     mode_q <= MODE_DATA;
            else if (wdata == MAGIC_CMD) mode_q <= MODE_CMD;
            else                         mode_q <= MODE_OFF;
        end
    end

    // Request generation toward the cursor and the memory.
    always_comb begin
        pg_load    = cmd_ok && (hit_ins || (hit_dat && mode_q == MODE_CMD));
        pg_idx     = wdata[PAGE_W-1:0];
        store_en   = hit_dat && (mode_q == MODE_DATA);
        store_byte = wdata[7:0];
    end

    // Read mux: only the interrupt-control word is visible.
    always_comb begin
        rdata = (addr == ADDR_W'(OFS_IRQCTL)) ? irqctl_q : 32'h0;
    end

    assert property (@(posedge clk) disable iff (!rst_n)
        hit_irq |=> (irqctl_q == $past(wdata)))
        else $error("assert_irqctl_keep_R2");

    assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_DATA) |-> !store_en)
        else $error("assert_no_store_outside_data_R3");

    assert property (@(posedge clk) disable iff (!rst_n)
        (hit_dat && mode_q == MODE_CMD) |-> !store_en)
        else $error("assert_cmd_mode_no_store_R5");

    always_comb begin
        if (rst_n) assert (mode_q == MODE_OFF || mode_q == MODE_DATA || mode_q == MODE_CMD)
            else $error("assert_mode_legal_R3");
    end
endmodule

// File: rtl/lcdpg_cursor.sv
// Write cursor: page and column pointer for pixel stores.
// A page load resets the column to 0. Each store advances the column
// modulo COLS. Assumes COLS is a power of two.
module lcdpg_cursor #(
    parameter int COLS  = 128,
    parameter int PAGES = 8,
    localparam int COL_W  = $clog2(COLS),
    localparam int PAGE_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_load,
    input  logic [PAGE_W-1:0] pg_idx,
    input  logic              store_en,
    output logic [PAGE_W-1:0] page,
    output logic [COL_W-1:0]  col
);
    // Pointer update: a page load wins over a store in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
            col  <= '0;
        end else if (pg_load) begin
            page <= pg_idx;
            col  <= '0;
        end else if (store_en) begin
            col  <= col + COL_W'(1);
        end
    end

    assert property (@(posedge clk) disable iff (!rst_n)
        pg_load |=> (col == '0 && page == $past(pg_idx)))
        else $error("assert_page_select_R4");

    assert property (@(posedge clk) disable iff (!rst_n)
        (store_en && !pg_load && col == COL_W'(COLS-1)) |=> (col == '0 && $stable(page)))
        else $error("assert_col_wrap_R7");

    assert property (@(posedge clk) disable iff (!rst_n)
        (store_en && !pg_load && col != COL_W'(COLS-1)) |=> (col == $past(col) + COL_W'(1)))
        else $error("assert_col_step_R6");
endmodule

// File: rtl/lcdpg_vram.sv
// Video memory with one write port and one independent scan read port.
// The scan returns the selected pixel bit one cycle after the coordinate.
// Contents are not reset.
module lcdpg_vram #(
    parameter int COLS   = 128,
    parameter int PAGES  = 8,
    parameter int PAGE_H = 8,
    localparam int COL_W  = $clog2(COLS),
    localparam int PAGE_W = $clog2(PAGES),
    localparam int BIT_W  = $clog2(PAGE_H),
    localparam int DEPTH  = COLS * PAGES,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [PAGE_W-1:0]       wpage,
    input  logic [COL_W-1:0]        wcol,
    input  logic [PAGE_H-1:0]       wbyte,
    input  logic [COL_W-1:0]        sx,
    input  logic [PAGE_W+BIT_W-1:0] sy,
    output logic                    spix
);
    logic [PAGE_H-1:0] mem [DEPTH];
    logic [PAGE_H-1:0] rbyte_q;
    logic [BIT_W-1:0]  bsel_q;
    logic [AW-1:0]     waddr, raddr;

    // Byte addresses: page * COLS + column.
    always_comb begin
        waddr = {wpage, wcol};
        raddr = {sy[PAGE_W+BIT_W-1:BIT_W], sx};
    end

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wbyte;
    end

    // Scan read port: register the byte and the bit select.
    always_ff @(posedge clk) begin
        rbyte_q <= mem[raddr];
        if (!rst_n) bsel_q <= '0;
        else        bsel_q <= sy[BIT_W-1:0];
    end

    // Pixel select from the registered byte.
    always_comb spix = rbyte_q[bsel_q];
endmodule

// File: rtl/lcdpg_ctrl.sv
// Top: page-addressed monochrome LCD controller.
// Connects the register decoder, the write cursor and the video memory.
// Assumes a 32-bit register bus with 12-bit byte offsets.
module lcdpg_ctrl #(
    parameter int ADDR_W = 12,
    parameter int COLS   = 128,
    parameter int PAGES  = 8,
    parameter int PAGE_H = 8,
    localparam int COL_W  = $clog2(COLS),
    localparam int PAGE_W = $clog2(PAGES),
    localparam int Y_W    = $clog2(PAGES * PAGE_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [COL_W-1:0]  scan_x,
    input  logic [Y_W-1:0]    scan_y,
    output logic              scan_pix
);
    logic              pg_load, store_en;
    logic [PAGE_W-1:0] pg_idx, page;
    logic [COL_W-1:0]  col;
    logic [7:0]        store_byte;

    lcdpg_regif #(.ADDR_W(ADDR_W), .PAGES(PAGES)) u_regif (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .pg_load(pg_load), .pg_idx(pg_idx),
        .store_en(store_en), .store_byte(store_byte)
    );

    lcdpg_cursor #(.COLS(COLS), .PAGES(PAGES)) u_cursor (
        .clk(clk), .rst_n(rst_n), .pg_load(pg_load), .pg_idx(pg_idx),
        .store_en(store_en), .page(page), .col(col)
    );

    lcdpg_vram #(.COLS(COLS), .PAGES(PAGES), .PAGE_H(PAGE_H)) u_vram (
        .clk(clk), .rst_n(rst_n), .we(store_en), .wpage(page), .wcol(col),
        .wbyte(PAGE_H'(store_byte)), .sx(scan_x), .sy(scan_y), .spix(scan_pix)
    );

    assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != ADDR_W'(12'h180)) |-> (reg_rdata == 32'h0))
        else $error("assert_read_zero_R2");
endmodule

// File: tb/tb_lcdpg_ctrl.sv
module tb_lcdpg_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [6:0]  scan_x = '0;
    logic [5:0]  scan_y = '0;
    logic        scan_pix;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    lcdpg_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scan_x(scan_x), .scan_y(scan_y), .scan_pix(scan_pix)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    localparam logic [11:0] A_IRQ = 12'h180, A_MOD = 12'h1AC, A_INS = 12'h1BC, A_DAT = 12'h1C0;
    localparam logic [31:0] M_DAT = 32'h0010_0011, M_CMD = 32'h0010_4011;

    typedef struct packed {
        logic        chk;
        logic [11:0] addr;
        logic [31:0] val;
        logic [6:0]  x;
        logic [5:0]  y;
        logic        exp;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VEC [NV] = '{
        '{1'b0, A_MOD, M_DAT,        7'd0, 6'd0,  1'b0},
        '{1'b0, A_INS, 32'hB2,       7'd0, 6'd0,  1'b0},
        '{1'b0, A_DAT, 32'hA5,       7'd0, 6'd0,  1'b0},
        '{1'b0, A_DAT, 32'h3C,       7'd0, 6'd0,  1'b0},
        '{1'b1, 12'h0, 32'h0,        7'd0, 6'd16, 1'b1},   // R6 / R8
        '{1'b1, 12'h0, 32'h0,        7'd0, 6'd17, 1'b0},
        '{1'b1, 12'h0, 32'h0,        7'd0, 6'd23, 1'b1},
        '{1'b1, 12'h0, 32'h0,        7'd1, 6'd16, 1'b0},
        '{1'b1, 12'h0, 32'h0,        7'd1, 6'd18, 1'b1},
        '{1'b0, A_DAT, 32'h1FF,      7'd0, 6'd0,  1'b0},
        '{1'b1, 12'h0, 32'h0,        7'd2, 6'd20, 1'b1},   // R6 low byte
        '{1'b0, A_MOD, M_CMD,        7'd0, 6'd0,  1'b0},
        '{1'b0, A_DAT, 32'hB5,       7'd0, 6'd0,  1'b0},   // R5 page via data reg
        '{1'b0, A_DAT, 32'h81,       7'd0, 6'd0,  1'b0},   // R5 ignored
        '{1'b0, A_MOD, M_DAT,        7'd0, 6'd0,  1'b0},
        '{1'b0, A_DAT, 32'h01,       7'd0, 6'd0,  1'b0},
        '{1'b0, A_DAT, 32'h80,       7'd0, 6'd0,  1'b0},
        '{1'b1, 12'h0, 32'h0,        7'd0, 6'd40, 1'b1},   // R5
        '{1'b1, 12'h0, 32'h0,        7'd1, 6'd47, 1'b1},   // R5
        '{1'b1, 12'h0, 32'h0,        7'd1, 6'd40, 1'b0},   // R5 nothing stored
        '{1'b1, 12'h0, 32'h0,        7'd0, 6'd16, 1'b1},   // page 2 intact
        '{1'b0, A_INS, 32'hB3,       7'd0, 6'd0,  1'b0},
        '{1'b0, A_DAT, 32'h00,       7'd0, 6'd0,  1'b0},
        '{1'b0, A_MOD, 32'h0010_0012,7'd0, 6'd0,  1'b0},   // R3 invalid
        '{1'b0, A_DAT, 32'hFF,       7'd0, 6'd0,  1'b0},
        '{1'b0, A_MOD, M_DAT,        7'd0, 6'd0,  1'b0},
        '{1'b0, A_DAT, 32'h02,       7'd0, 6'd0,  1'b0},
        '{1'b1, 12'h0, 32'h0,        7'd0, 6'd24, 1'b0},   // R3
        '{1'b1, 12'h0, 32'h0,        7'd1, 6'd25, 1'b1},   // R3 column not advanced
        '{1'b1, 12'h0, 32'h0,        7'd1, 6'd24, 1'b0},
        '{1'b0, A_INS, 32'hB8,       7'd0, 6'd0,  1'b0},   // R4 ignored
        '{1'b0, A_DAT, 32'h04,       7'd0, 6'd0,  1'b0},
        '{1'b1, 12'h0, 32'h0,        7'd2, 6'd26, 1'b1},   // R4
        '{1'b0, A_INS, 32'h1B1,      7'd0, 6'd0,  1'b0},   // R4 ignored
        '{1'b0, A_DAT, 32'h08,       7'd0, 6'd0,  1'b0},
        '{1'b1, 12'h0, 32'h0,        7'd3, 6'd27, 1'b1}    // R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pix(input string req, input logic [6:0] x, input logic [5:0] y, input logic exp);
        @(negedge clk);
        scan_x = x; scan_y = y;
        @(negedge clk);
        check(req, {31'd0, scan_pix}, {31'd0, exp});
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 check(req, reg_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd("R1 irqctl after reset", A_IRQ, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].chk) pix("R8 table pixel", VEC[i].x, VEC[i].y, VEC[i].exp);
            else            wr(VEC[i].addr, VEC[i].val);
        end

        // R2 readback and zero reads
        wr(A_IRQ, 32'hDEAD_BEEF);
        rd("R2 irqctl readback", A_IRQ, 32'hDEAD_BEEF);
        rd("R2 mode reads zero", A_MOD, 32'h0);
        rd("R2 instr reads zero", A_INS, 32'h0);
        rd("R2 data reads zero", A_DAT, 32'h0);
        rd("R2 other reads zero", 12'h000, 32'h0);

        // R7 wrap in page 7
        wr(A_INS, 32'hB7);
        for (int c = 0; c < 128; c++)
            wr(A_DAT, (c == 0) ? 32'h01 : ((c == 127) ? 32'h80 : 32'h00));
        wr(A_DAT, 32'h10);
        pix("R7 wrapped byte at column 0", 7'd0, 6'd60, 1'b1);
        pix("R7 old column 0 replaced", 7'd0, 6'd56, 1'b0);
        pix("R7 last column kept", 7'd127, 6'd63, 1'b1);

        // R1 reset during operation
        wr(A_INS, 32'hB4);
        wr(A_DAT, 32'h01);
        wr(A_DAT, 32'h01);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd("R1 irqctl cleared", A_IRQ, 32'h0);
        wr(A_DAT, 32'hFF);
        pix("R1 mode invalid after reset", 7'd0, 6'd33, 1'b0);
        pix("R1 memory kept over reset", 7'd1, 6'd32, 1'b1);
        wr(A_MOD, M_DAT);
        wr(A_DAT, 32'h40);
        pix("R1 cursor at page 0 column 0", 7'd0, 6'd6, 1'b1);

        // R9 store and scan in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_DAT; reg_wdata = 32'h80;
        scan_x = 7'd0; scan_y = 6'd6;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R9 scan during store", {31'd0, scan_pix}, 32'd1);
        pix("R9 concurrent store landed", 7'd1, 6'd7, 1'b1);

        finish_run();
    end
endmodule